// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept, based only on its 48-bit destination address. A receive path presents the destination address and pulses `start`. The block captures the address and the receive-mode byte, then runs a serial CRC over the address, one bit per clock, to form a 6-bit index into a 64-bit multicast hash table. When the last address bit has been folded in, it pulses `done` and publishes the accept decision, the hash index and a group-address flag. These outputs stay put until the next accepted `start`.

Four address classes are resolved in a fixed priority. Promiscuous mode keeps everything. The all-ones broadcast address is next. Then come group (multicast) addresses, which go through the hash table. Any other destination must match the station address exactly. The station address and hash table are treated as quasi-static configuration and are sampled on the final CRC step. Every decision takes the same number of cycles, whatever the address class.

Top module: `rx_addr_filter`

## Requirements
- R1: When `rx_cfg` bit 4 is 1, `accept` is 1 at `done` for any destination address.
- R2: With `rx_cfg` bit 4 clear, a destination of all ones (broadcast) gives `accept` equal to `rx_cfg` bit 2. The multicast and unicast rules are not consulted.
- R3: With `rx_cfg` bit 4 clear, a destination that is not broadcast and whose byte 0 (`dest_addr[7:0]`) has bit 0 set is accepted only if `rx_cfg` bit 3 is 1 and the hash-table bit selected by the hash index is 1.
- R4: `hash_idx` equals bits [31:26] of a CRC register. The register starts at all ones and processes address bits `dest_addr[0]` through `dest_addr[47]` in order (byte k is `dest_addr[8k+7:8k]`, least significant bit first). Each step computes c = crc[31] XOR bit and shifts the register left by one; when c is 1, the shifted value is XORed with 0x04C11DB6 and bit 0 is forced to 1.
- R5: The hash-table bit for index i is `hash_table[8*i[5:3] + i[2:0]]`: index bits [5:3] pick the byte and bits [2:0] pick the bit within that byte.
- R6: With `rx_cfg` bit 4 clear, a destination whose byte 0 bit 0 is clear is accepted only if it equals `station_addr` in all 48 bits.
- R7: `done` is a one-cycle pulse on the 48th rising edge after the edge that takes `start`. `busy` is 1 from the edge after `start` until `done` rises, and `busy` and `done` are never 1 together.
- R8: `accept`, `hash_idx` and `group_addr` change only when `done` rises and hold until the next decision. A `start` while `busy` is 1 is ignored and does not change the running decision.
- R9: At `done`, `group_addr` equals bit 0 of byte 0 of the captured destination.
- R10: After reset, `busy`, `done`, `accept`, `group_addr` and `hash_idx` are all 0.
- R11: `dest_addr` and `rx_cfg` are captured on the `start` edge, so changes to them afterwards do not affect that decision. Bits of `rx_cfg` other than 2, 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decision for the presented address |
| dest_addr | input | 48 | Destination address, byte 0 in bits [7:0] |
| rx_cfg | input | 8 | Receive mode: bit 4 keep-all, bit 3 multicast enable, bit 2 broadcast enable |
| station_addr | input | 48 | Own unicast address, same byte layout |
| hash_table | input | 64 | Multicast hash table, byte j in bits [8j+7:8j] |
| busy | output | 1 | CRC walk in progress |
| done | output | 1 | One-cycle pulse: decision outputs updated |
| accept | output | 1 | Frame is to be kept |
| group_addr | output | 1 | Destination is a group (multicast or broadcast) address |
| hash_idx | output | 6 | Hash index computed from the last address |

## Verification
The bound checker enforces the following on every cycle:
- the `done` pulse shape and its fixed 48-cycle latency, measured with its own counter;
- the exclusion between `busy` and `done`;
- that the decision outputs hold between decisions;
- the keep-all override;
- the exact station comparison for individual addresses;
- the group flag.

The CRC index value, the hash-table byte and bit selection, the broadcast and multicast enables with their priority order, the capture of inputs at `start`, and the ignored restart can only be shown by the bench. The bench sweeps every combination of the mode bits against each address class. It then walks a set of multicast addresses, placing the table bit at the computed index and at a neighbouring byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  // bit positions inside the receive-mode byte
  localparam int unsigned MODE_BCAST_BIT   = 2;
  localparam int unsigned MODE_MCAST_BIT   = 3;
  localparam int unsigned MODE_PROMISC_BIT = 4;

  typedef struct packed {
    logic promisc;
    logic mcast_en;
    logic bcast_en;
  } rx_mode_t;

  typedef struct packed {
    logic is_bcast;
    logic is_group;
    logic uni_hit;
  } addr_class_t;

  // One serial CRC step; the feedback carry is ORed into bit 0.
  function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] c,
                                                   input logic d);
    logic            fb;
    logic [CRC_W-1:0] s;
    fb = c[CRC_W-1] ^ d;
    s  = {c[CRC_W-2:0], 1'b0};
    if (fb) s = (s ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    return s;
  endfunction

endpackage

// File: rtl/rxf_crc_engine.sv
module rxf_crc_engine #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              fin,
  output logic [HASH_W-1:0] hash_nxt
);
  import rxf_pkg::*;

  localparam int unsigned CW = $clog2(ADDR_W);
  localparam logic [CW-1:0] LAST = CW'(ADDR_W - 1);

  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CW-1:0]    cnt_q;
  logic             busy_q;

  assign crc_d    = crc_advance(crc_q, addr[cnt_q]);
  assign fin      = busy_q && (cnt_q == LAST);
  assign hash_nxt = crc_d[CRC_W-1 -: HASH_W];
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= CRC_SEED;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      crc_q  <= CRC_SEED;
    end else if (busy_q) begin
      crc_q <= crc_d;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic [8*ADDR_BYTES-1:0] dest,
  input  logic [8*ADDR_BYTES-1:0] station,
  output rxf_pkg::addr_class_t    cls
);
  logic [ADDR_BYTES-1:0] byte_ones;
  logic [ADDR_BYTES-1:0] byte_eq;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    assign byte_ones[b] = &dest[8*b +: 8];
    assign byte_eq[b]   = (dest[8*b +: 8] == station[8*b +: 8]);
  end

  assign cls.is_bcast = &byte_ones;
  assign cls.is_group = dest[0];
  assign cls.uni_hit  = &byte_eq;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
  parameter int unsigned HASH_W = 6
) (
  input  rxf_pkg::rx_mode_t       mode,
  input  rxf_pkg::addr_class_t    cls,
  input  logic [(1<<HASH_W)-1:0]  table_bits,
  input  logic [HASH_W-1:0]       idx,
  output logic                    keep
);
  logic [7:0] row;
  logic       hash_hit;

  // upper index bits choose the byte, low three the bit in it
  assign row      = table_bits[{idx[HASH_W-1:3], 3'b000} +: 8];
  assign hash_hit = row[idx[2:0]];

  always_comb begin
    if (mode.promisc)       keep = 1'b1;
    else if (cls.is_bcast)  keep = mode.bcast_en;
    else if (cls.is_group)  keep = mode.mcast_en && hash_hit;
    else                    keep = cls.uni_hit;
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_W     = 6,
  parameter int unsigned CFG_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [8*ADDR_BYTES-1:0]   dest_addr,
  input  logic [CFG_W-1:0]          rx_cfg,
  input  logic [8*ADDR_BYTES-1:0]   station_addr,
  input  logic [(1<<HASH_W)-1:0]    hash_table,
  output logic                      busy,
  output logic                      done,
  output logic                      accept,
  output logic                      group_addr,
  output logic [HASH_W-1:0]         hash_idx
);
  import rxf_pkg::*;

  localparam int unsigned ADDR_W = 8 * ADDR_BYTES;

  logic [ADDR_W-1:0] dest_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              go;
  logic              fin;
  logic [HASH_W-1:0] idx_nxt;
  logic              keep_nxt;
  rx_mode_t          mode;
  addr_class_t       cls;
  logic              unused_cfg_bits;

  assign go   = start && !busy;
  assign mode = '{promisc:  cfg_q[MODE_PROMISC_BIT],
                  mcast_en: cfg_q[MODE_MCAST_BIT],
                  bcast_en: cfg_q[MODE_BCAST_BIT]};
  assign unused_cfg_bits = ^cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
      cfg_q  <= '0;
    end else if (go) begin
      dest_q <= dest_addr;
      cfg_q  <= rx_cfg;
    end
  end

  rxf_crc_engine #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .load(go), .addr(dest_q),
    .busy(busy), .fin(fin), .hash_nxt(idx_nxt)
  );

  rxf_classify #(.ADDR_BYTES(ADDR_BYTES)) u_cls (
    .dest(dest_q), .station(station_addr), .cls(cls)
  );

  rxf_decide #(.HASH_W(HASH_W)) u_dec (
    .mode(mode), .cls(cls), .table_bits(hash_table), .idx(idx_nxt), .keep(keep_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      accept     <= 1'b0;
      group_addr <= 1'b0;
      hash_idx   <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        accept     <= keep_nxt;
        group_addr <= cls.is_group;
        hash_idx   <= idx_nxt;
      end
    end
  end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_W     = 6,
  parameter int unsigned CFG_W      = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    accept,
  input logic                    group_addr,
  input logic [HASH_W-1:0]       hash_idx,
  input logic [8*ADDR_BYTES-1:0] station_addr,
  input logic [8*ADDR_BYTES-1:0] dest_q,
  input logic [CFG_W-1:0]        cfg_q
);
  localparam int unsigned LAT = 8 * ADDR_BYTES;
  localparam int unsigned LW  = $clog2(LAT) + 2;

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy && lat_q != '1) lat_q <= lat_q + 1'b1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(LAT)));
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(accept) && $stable(hash_idx) && $stable(group_addr)));
  // R1
  promisc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_q[4]) |-> accept);
  // R6
  unicast_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_q[4] && !dest_q[0]) |-> (accept == ($past(station_addr) == dest_q)));
  // R9
  group_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (group_addr == dest_q[0]));

endmodule

bind rx_addr_filter rxf_checker #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .accept(accept), .group_addr(group_addr), .hash_idx(hash_idx),
  .station_addr(station_addr), .dest_q(dest_q), .cfg_q(cfg_q)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STATION = 48'hAB89_6745_2302;
  localparam logic [47:0] MC_BASE = 48'h3300_0000_5E01;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [47:0] dest_addr = '0;
  logic [7:0]  rx_cfg = '0;
  logic [47:0] station_addr = STATION;
  logic [63:0] hash_table = '0;
  logic        busy, done, accept, group_addr;
  logic [5:0]  hash_idx;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dest_addr(dest_addr), .rx_cfg(rx_cfg),
    .station_addr(station_addr), .hash_table(hash_table), .busy(busy), .done(done),
    .accept(accept), .group_addr(group_addr), .hash_idx(hash_idx)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] r;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = r[31] ^ a[k];
      r  = (r << 1) ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return r[31:26];
  endfunction

  function automatic logic ref_keep(input logic [47:0] d, input logic [7:0] c,
                                    input logic [63:0] t, input logic [47:0] st);
    if (c[4])               return 1'b1;
    if (d == 48'hFFFF_FFFF_FFFF) return c[2];
    if (d[0])               return c[3] && t[ref_hash(d)];
    return d == st;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // start a decision, wait for done; lat = rising edges after the start edge
  task automatic launch(input logic [47:0] d, input logic [7:0] c, input logic [63:0] t,
                        output int lat);
    @(negedge clk);
    dest_addr = d; rx_cfg = c; hash_table = t; start = 1;
    @(negedge clk);
    start = 0; lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic judge(input logic [47:0] d, input logic [7:0] c, input logic [63:0] t,
                       input string req);
    int lat;
    logic e;
    launch(d, c, t, lat);
    e = ref_keep(d, c, t, STATION);
    chk(lat == 48, "R7 latency", 64'(lat), 64'd48);
    chk(accept == e, req, {63'b0, accept}, {63'b0, e});
    chk(group_addr == d[0], "R9 group flag", {63'b0, group_addr}, {63'b0, d[0]});
  endtask

  initial begin
    logic [47:0] addrs [5];
    logic [47:0] d;
    logic [5:0]  hi;
    logic [63:0] t;
    logic        held_acc;
    logic [5:0]  held_idx;
    int          lat;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, accept, group_addr, hash_idx} == '0, "R10 reset outputs",
        {54'b0, busy, done, accept, group_addr, hash_idx}, 64'd0);
    rst_n = 1;

    addrs[0] = 48'hFFFF_FFFF_FFFF;
    addrs[1] = STATION;
    addrs[2] = STATION ^ 48'h0100_0000_0000;
    addrs[3] = MC_BASE;
    addrs[4] = MC_BASE;

    // R1 R2 R3 R6 R11: mode byte sweep against every address class
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 5; k++) begin
        hi = ref_hash(addrs[k]);
        t  = (k == 4) ? ~(64'd1 << hi) : (64'd1 << hi);
        judge(addrs[k], 8'(c) | 8'hC0, t,
              k == 0 ? "R2 broadcast" : (k >= 3 ? "R3 multicast" :
              (c[4] ? "R1 promiscuous" : "R6 unicast")));
      end
    end

    // R4 R5: hash index and table bit placement over many group addresses
    for (int k = 0; k < 64; k++) begin
      d  = MC_BASE ^ (48'(k) << 17) ^ (48'(k) << 9);
      hi = ref_hash(d);
      launch(d, 8'h08, 64'd1 << hi, lat);
      chk(hash_idx == hi, "R4 hash index", {58'b0, hash_idx}, {58'b0, hi});
      chk(accept == 1'b1, "R5 table bit hit", {63'b0, accept}, 64'd1);
      launch(d, 8'h08, 64'd1 << (hi ^ 6'b001000), lat);
      chk(accept == 1'b0, "R5 neighbour byte miss", {63'b0, accept}, 64'd0);
    end

    // R11: inputs changed right after start do not alter the decision
    @(negedge clk);
    dest_addr = STATION; rx_cfg = 8'h00; start = 1;
    @(negedge clk);
    start = 0; dest_addr = 48'hFFFF_FFFF_FFFF; rx_cfg = 8'h00;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(accept == 1'b1, "R11 capture at start", {63'b0, accept}, 64'd1);

    // R8: restart while busy is ignored
    @(negedge clk);
    dest_addr = addrs[2]; rx_cfg = 8'h00; start = 1;
    @(negedge clk);
    start = 0; lat = 0;
    repeat (10) begin @(negedge clk); lat++; end
    dest_addr = STATION; rx_cfg = 8'h10; start = 1;
    @(negedge clk);
    start = 0; lat++;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == 48, "R8 restart ignored latency", 64'(lat), 64'd48);
    chk(accept == 1'b0, "R8 restart ignored result", {63'b0, accept}, 64'd0);

    // R8: outputs hold after done while inputs move
    held_acc = accept; held_idx = hash_idx;
    dest_addr = STATION; rx_cfg = 8'h1C; hash_table = '1;
    repeat (6) @(negedge clk);
    chk(!done, "R7 done is a pulse", {63'b0, done}, 64'd0);
    chk(accept == held_acc && hash_idx == held_idx, "R8 hold",
        {57'b0, accept, hash_idx}, {57'b0, held_acc, held_idx});
    chk(!busy, "R7 idle after done", {63'b0, busy}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule